// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Bank

This block turns activity on a bank of general-purpose input pins into a single interrupt request. Each pin has its own two-bit trigger code. The code selects detection of rising edges, falling edges, both edges, or nothing. Level sensing is not offered. The pins arrive asynchronously, so each passes through a synchroniser. An edge is found by comparing the newest synchronised sample with the sample taken one clock earlier.

A detected edge sets a sticky per-pin event bit. The bit stays set until software writes a one to it. A separate per-pin mask gates which event bits may raise the bank interrupt line. Writing ones through the mask-set operation masks pins, and writing ones through the mask-clear operation unmasks them. The mask never stops an event bit from being recorded. The bank interrupt is high whenever any unmasked event bit is set. After reset every pin is masked and every event bit is clear.

Software drives a single write port, made of an operation code and a data word. One operation can be applied per clock. The event and mask registers are brought out directly so the surrounding register file can read them.

Top module: `gpio_edge_irq_bank`

## Requirements
- R1: While and after reset, `eventBits` is all zeros, `maskBits` is all ones and `bankIrq` is low.
- R2: A pin whose trigger code is 1 sets its event bit on a 0-to-1 change of its synchronised input. For a pin change set up before clock edge k, the bit reads as set after clock edge k+2.
- R3: A pin whose trigger code is 2 sets its event bit on a 1-to-0 change, with the same latency as R2.
- R4: A pin whose trigger code is 3 sets its event bit on either change, with the same latency as R2.
- R5: A pin whose trigger code is 0 never sets its event bit. Pin p's code sits in `trigType[2p+1:2p]`.
- R6: Event bits are sticky. With `wrOp` = 1, each bit where `wrData` is 1 is cleared at the next edge, and bits where `wrData` is 0 keep their value.
- R7: With `wrOp` = 2, each mask bit where `wrData` is 1 becomes 1 at the next edge. The other mask bits are unchanged.
- R8: With `wrOp` = 3, each mask bit where `wrData` is 1 becomes 0 at the next edge. The other mask bits are unchanged.
- R9: `bankIrq` is high exactly when some bit is set in `eventBits` and clear in `maskBits`, in the same cycle.
- R10: If a new edge and a clear (`wrOp` = 1) hit the same bit on the same clock edge, the bit ends up set.
- R11: A masked pin still records its edges in `eventBits`.
- R12: With `wrOp` = 0, neither `eventBits` nor `maskBits` is changed by `wrData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pinIn | input | PINS | Asynchronous pin levels |
| trigType | input | 2*PINS | Per-pin trigger code, pin p at bits 2p+1:2p (0 none, 1 rising, 2 falling, 3 both) |
| wrOp | input | 2 | Write operation: 0 idle, 1 clear events, 2 set mask, 3 clear mask |
| wrData | input | PINS | Per-pin bit vector for the write operation |
| eventBits | output | PINS | Sticky edge-event register |
| maskBits | output | PINS | Interrupt mask register, 1 = masked |
| bankIrq | output | 1 | Bank interrupt request |

## Verification
A fault in the synchroniser or edge comparator shows up in `eventBits` as a bit set one cycle early or late, or not set at all, exactly three clock edges after a pin change. A wrong mask or event register reaches `bankIrq` in the same cycle, because the interrupt is a plain combination of the two. The event bits are sticky, so a missed or spurious edge stays visible until the next clear, and the cycle-accurate comparison catches it at the first sample after it happens. The clear-versus-edge collision is set up deliberately, so that the single cycle in which it matters is exercised.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE       = 2'd0,
    OP_CLR_EVENT  = 2'd1,
    OP_MASK_SET   = 2'd2,
    OP_MASK_CLR   = 2'd3
  } wr_op_e;

  // Trigger code: bit 0 enables rising detection, bit 1 enables falling.
  localparam logic [1:0] TRIG_NONE = 2'd0;
  localparam logic [1:0] TRIG_RISE = 2'd1;
  localparam logic [1:0] TRIG_FALL = 2'd2;
  localparam logic [1:0] TRIG_BOTH = 2'd3;

  typedef struct packed {
    logic clrEvent;
    logic setMask;
    logic clrMask;
  } strobes_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic [1:0] wrOp,
  output strobes_t   strb
);
  always_comb begin
    strb = '0;
    unique case (wr_op_e'(wrOp))
      OP_CLR_EVENT: strb.clrEvent = 1'b1;
      OP_MASK_SET:  strb.setMask  = 1'b1;
      OP_MASK_CLR:  strb.clrMask  = 1'b1;
      default:      strb = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PINS-1:0]   pinIn,
  input  logic [2*PINS-1:0] trigType,
  input  logic [PINS-1:0]   wrData,
  input  strobes_t          strb,
  output logic [PINS-1:0]   eventBits,
  output logic [PINS-1:0]   maskBits,
  output logic              bankIrq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [PINS-1:0] syncQ [SYNC_STAGES];
  logic [PINS-1:0] prevQ;
  logic [PINS-1:0] edgeHit;
  logic [PINS-1:0] clrBits;
  logic [PINS-1:0] mSetBits;
  logic [PINS-1:0] mClrBits;
  logic [PINS-1:0] eventQ;
  logic [PINS-1:0] maskQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : gEdge
    logic riseEn;
    logic fallEn;
    assign riseEn     = trigType[2*i];
    assign fallEn     = trigType[2*i+1];
    assign edgeHit[i] = (riseEn &  syncQ[LAST][i] & ~prevQ[i]) |
                        (fallEn & ~syncQ[LAST][i] &  prevQ[i]);
  end

  assign clrBits  = strb.clrEvent ? wrData : '0;
  assign mSetBits = strb.setMask  ? wrData : '0;
  assign mClrBits = strb.clrMask  ? wrData : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eventQ <= '0;
      maskQ  <= '1;
    end else begin
      // a fresh edge wins over a clear on the same bit
      eventQ <= (eventQ & ~clrBits) | edgeHit;
      maskQ  <= (maskQ | mSetBits) & ~mClrBits;
    end
  end

  assign eventBits = eventQ;
  assign maskBits  = maskQ;
  assign bankIrq   = |(eventQ & ~maskQ);
endmodule

// File: rtl/gpio_edge_irq_bank.sv
module gpio_edge_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PINS-1:0]   pinIn,
  input  logic [2*PINS-1:0] trigType,
  input  logic [1:0]        wrOp,
  input  logic [PINS-1:0]   wrData,
  output logic [PINS-1:0]   eventBits,
  output logic [PINS-1:0]   maskBits,
  output logic              bankIrq
);
  strobes_t strb;

  gpio_irq_ctrl uCtrl (
    .wrOp (wrOp),
    .strb (strb)
  );

  gpio_irq_datapath #(
    .PINS        (PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .trigType  (trigType),
    .wrData    (wrData),
    .strb      (strb),
    .eventBits (eventBits),
    .maskBits  (maskBits),
    .bankIrq   (bankIrq)
  );
endmodule

// File: rtl/gpio_edge_irq_bank_chk.sv
module gpio_edge_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [2*PINS-1:0] trigType,
  input logic [1:0]        wrOp,
  input logic [PINS-1:0]   wrData,
  input logic [PINS-1:0]   eventBits,
  input logic [PINS-1:0]   maskBits,
  input logic              bankIrq
);
  logic [PINS-1:0] deadPins;
  logic [PINS-1:0] allowedClr;

  always_comb begin
    for (int i = 0; i < PINS; i++) deadPins[i] = (trigType[2*i +: 2] == TRIG_NONE);
  end
  assign allowedClr = (wrOp == OP_CLR_EVENT) ? wrData : '0;

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (eventBits == '0) && (maskBits == '1)); // R1

  AST_DEAD_PIN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((eventBits & ~$past(eventBits) & $past(deadPins)) == '0)); // R5

  AST_EVENT_DROP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (($past(eventBits) & ~eventBits & ~$past(allowedClr)) == '0)); // R6

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wrOp == OP_MASK_SET) |=> ((maskBits & $past(wrData)) == $past(wrData))); // R7

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (wrOp == OP_MASK_CLR) |=> ((maskBits & $past(wrData)) == '0)); // R8

  AST_NO_EVENT_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (eventBits == '0) |-> !bankIrq); // R9

  AST_IDLE_MASK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (wrOp == OP_IDLE) |=> $stable(maskBits)); // R12
endmodule

bind gpio_edge_irq_bank gpio_edge_irq_bank_chk #(.PINS(PINS)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .trigType  (trigType),
  .wrOp      (wrOp),
  .wrData    (wrData),
  .eventBits (eventBits),
  .maskBits  (maskBits),
  .bankIrq   (bankIrq)
);

// File: tb/tb_gpio_edge_irq_bank.sv
module tb_gpio_edge_irq_bank;
  localparam int PINS = 32;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rstN;
  logic [PINS-1:0]   pinIn;
  logic [2*PINS-1:0] trigType;
  logic [1:0]        wrOp;
  logic [PINS-1:0]   wrData;
  logic [PINS-1:0]   eventBits;
  logic [PINS-1:0]   maskBits;
  logic              bankIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  gpio_edge_irq_bank #(.PINS(PINS)) dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .trigType(trigType),
    .wrOp(wrOp), .wrData(wrData),
    .eventBits(eventBits), .maskBits(maskBits), .bankIrq(bankIrq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements (two sync stages + compare).
  logic [PINS-1:0] m1, m2, m3, expEvent, expMask;

  function automatic logic [PINS-1:0] edgesOf(logic [PINS-1:0] cur, logic [PINS-1:0] old,
                                              logic [2*PINS-1:0] tt);
    logic [PINS-1:0] r;
    for (int i = 0; i < PINS; i++) begin
      r[i] = 1'b0;
      if (cur[i] && !old[i] && (tt[2*i +: 2] == 2'd1 || tt[2*i +: 2] == 2'd3)) r[i] = 1'b1;
      if (!cur[i] && old[i] && (tt[2*i +: 2] == 2'd2 || tt[2*i +: 2] == 2'd3)) r[i] = 1'b1;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      m1 <= '0; m2 <= '0; m3 <= '0;
      expEvent <= '0;
      expMask  <= '1;
    end else begin
      m1 <= pinIn; m2 <= m1; m3 <= m2;
      expEvent <= (expEvent & ~((wrOp == 2'd1) ? wrData : '0)) | edgesOf(m2, m3, trigType);
      if (wrOp == 2'd2) expMask <= expMask | wrData;
      else if (wrOp == 2'd3) expMask <= expMask & ~wrData;
    end
  end

  task automatic check(input bit ok, input string req, input logic [PINS-1:0] act,
                       input logic [PINS-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string req);
    check(eventBits == expEvent, {req, " eventBits"}, eventBits, expEvent);
    check(maskBits == expMask, {req, " maskBits (R7/R8)"}, maskBits, expMask);
    check(bankIrq == |(expEvent & ~expMask), {req, " bankIrq R9"},
          {31'd0, bankIrq}, {31'd0, |(expEvent & ~expMask)});
  endtask

  task automatic step(input string req);
    @(posedge clk);
    @(negedge clk);
    compareAll(req);
  endtask

  function automatic logic [2*PINS-1:0] codePattern();
    logic [2*PINS-1:0] t;
    for (int i = 0; i < PINS; i++) t[2*i +: 2] = 2'(i % 4);
    return t;
  endfunction

  function automatic logic [PINS-1:0] pinsWith(logic [2*PINS-1:0] tt, logic [1:0] code);
    logic [PINS-1:0] r;
    for (int i = 0; i < PINS; i++) r[i] = (tt[2*i +: 2] == code);
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [PINS-1:0] setR, setF, setN, setB;
    int unused;
    unused = $urandom(32'h5eed);
    rstN = 1'b0; pinIn = '0; trigType = '0; wrOp = 2'd0; wrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(eventBits == '0, "R1 reset events", eventBits, '0);
    check(maskBits == '1, "R1 reset mask", maskBits, '1);
    check(!bankIrq, "R1 reset irq", {31'd0, bankIrq}, '0);
    rstN = 1'b1;
    step("R1");

    // R12: idle op with nonzero data leaves registers unchanged
    wrOp = 2'd0; wrData = '1;
    step("R12");
    check(maskBits == '1, "R12 idle mask", maskBits, '1);
    wrData = '0;

    // Directed per-code check: pin p uses code p%4, all unmasked
    trigType = codePattern();
    setN = pinsWith(trigType, 2'd0); setR = pinsWith(trigType, 2'd1);
    setF = pinsWith(trigType, 2'd2); setB = pinsWith(trigType, 2'd3);
    wrOp = 2'd3; wrData = '1; step("R8"); wrOp = 2'd0; wrData = '0;
    check(maskBits == '0, "R8 unmask all", maskBits, '0);
    pinIn = '1;
    step("R2"); step("R2");
    check(eventBits == '0, "R2 latency not early", eventBits, '0);
    step("R2");
    check((eventBits & setR) == setR, "R2 rising", eventBits, setR);
    check((eventBits & setB) == setB, "R4 both rising", eventBits, setB);
    check((eventBits & (setF | setN)) == '0, "R3/R5 no rise", eventBits, '0);
    check(bankIrq, "R9 irq on event", {31'd0, bankIrq}, 1);
    wrOp = 2'd1; wrData = setR; step("R6"); wrOp = 2'd0; wrData = '0;
    check(eventBits == setB, "R6 partial clear", eventBits, setB);
    wrOp = 2'd1; wrData = '1; step("R6"); wrOp = 2'd0; wrData = '0;
    check(eventBits == '0, "R6 full clear", eventBits, '0);
    pinIn = '0;
    repeat (3) step("R3");
    check(eventBits == (setF | setB), "R3 falling and R4 both", eventBits, setF | setB);
    check((eventBits & setN) == '0, "R5 code zero silent", eventBits, '0);

    // R11: masked pins still latch
    wrOp = 2'd1; wrData = '1; step("R6");
    wrOp = 2'd2; wrData = '1; step("R7"); wrOp = 2'd0; wrData = '0;
    check(maskBits == '1, "R7 mask all", maskBits, '1);
    pinIn = '1;
    repeat (3) step("R11");
    check(eventBits == (setR | setB), "R11 masked still latched", eventBits, setR | setB);
    check(!bankIrq, "R9 masked irq low", {31'd0, bankIrq}, '0);

    // R10: clear and new edge on pin 1 (code 1) in the same cycle
    wrOp = 2'd1; wrData = '1; step("R6"); wrOp = 2'd0; wrData = '0;
    pinIn = '0; repeat (3) step("R10");
    wrOp = 2'd1; wrData = '1; step("R10"); wrOp = 2'd0; wrData = '0;
    pinIn[1] = 1'b1;
    step("R10"); step("R10");
    wrOp = 2'd1; wrData = 32'h2;
    step("R10");
    check(eventBits[1], "R10 edge beats clear", {31'd0, eventBits[1]}, 1);
    wrOp = 2'd0; wrData = '0;

    // Constrained random phase
    for (int c = 0; c < 4000; c++) begin
      if (c % 64 == 0) trigType = {$urandom, $urandom};
      pinIn = pinIn ^ ($urandom & $urandom & $urandom);
      case ($urandom % 8)
        0: begin wrOp = 2'd1; wrData = $urandom; end
        1: begin wrOp = 2'd2; wrData = $urandom & $urandom; end
        2: begin wrOp = 2'd3; wrData = $urandom; end
        default: begin wrOp = 2'd0; wrData = $urandom; end
      endcase
      step("R2-random");
    end
    wrOp = 2'd0; wrData = '0;
    step("R12");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule